// File: doc/BRIEF.md
# Multiplexed LCD Row Scanner

This block scans a passive multiplexed LCD. It walks through 2, 4 or 8 display rows. A clock divider sets the row period, so a whole frame always takes the same number of system clocks whatever the mux ratio. At the start of each row period the block loads the RAM word of the current row into a display latch. It then gives each panel output a 3-bit level-select code. An analog stage outside the block turns that code into a bias voltage.

With `col_only` low the block drives both rows and columns. The lowest n outputs become row drivers, the rest are column drivers, and the block makes the frame polarity itself and drives it out on `fr_out` for devices further down a chain. With `col_only` high every output is a column driver. The polarity then comes from `ext_fr`, and each edge on `ext_fr` sends the row sequence back to row 0.

Two override inputs force the column pixels: `blank` turns them all off and `set_all` turns them all on. Raising both inputs at once is a synchronise request, which resets the row sequence and the divider without forcing any pixel.

Top module: `lcd_row_scanner`

## Requirements
- R1: While `rst_n` is low, the latch is cleared, `ram_addr` is 0 and `fr_out` is 0. The outputs then show row 0 selected, polarity 0 and every column off.
- R2: A row lasts FRAME_CLKS/n clocks. Rows run 0,1,...,n-1 and then wrap to 0. `ram_addr` moves to the next row one clock before the latch and the outputs show it.
- R3: In row-and-column mode the polarity toggles after the last row of each frame. `fr_out` carries it one clock before the outputs take it.
- R4: The latch captures the RAM word for the current row. Output i shows bit i of that word, and a 1 means the pixel is on.
- R5: In row-and-column mode, outputs 0..n-1 are rows and the rest are columns. In column-only mode, every output is a column.
- R6: Level codes are 0=VSS, 1=V3, 2=V2, 3=V1, 4=VLCD. For mux 2 and mux 8 at polarity 0: selected row 0, unselected row 3, column on 4, column off 2. At polarity 1: selected row 4, unselected row 1, column on 0, column off 2.
- R7: For mux 4 at polarity 0: selected row 0, unselected row 3, column on 4, column off 2. At polarity 1: selected row 4, unselected row 2, column on 0, column off 3. Code 1 is never produced in mux 4.
- R8: `blank` alone forces every column to its off level in the same cycle. Rows and the sequence are not affected.
- R9: `set_all` alone forces every column to its on level in the same cycle. Rows and the sequence are not affected.
- R10: `blank` and `set_all` high together force no pixels. They hold the row at 0, the divider at 0 and the polarity at 0. After they are released, timing restarts exactly as it does after reset.
- R11: In column-only mode, `ext_fr` passes through a two-flop synchroniser. The third rising edge after `ext_fr` changes restarts the sequence at row 0 and takes the new polarity. `fr_out` follows one clock earlier.
- R12: `mux_sel` encoding: 0 selects 2 rows, 1 selects 4 rows, and 2 or 3 select 8 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_sel | input | 2 | Mux ratio select |
| col_only | input | 1 | 1 = all outputs are columns, slaved to `ext_fr` |
| blank | input | 1 | Force columns off |
| set_all | input | 1 | Force columns on |
| ext_fr | input | 1 | External frame polarity (column-only mode) |
| ram_addr | output | 3 | Display RAM row address |
| ram_rdata | input | NUM_OUT | RAM word, combinational read of `ram_addr` |
| fr_out | output | 1 | Frame polarity for cascaded devices |
| seg_lvl | output | 3*NUM_OUT | Level code per output, output i at bits 3i+2..3i |

## Verification
The bench sweeps each mux ratio over two full frames. These sweeps catch a divider that does not scale with n, which would give a wrong row period, and a wrap at the wrong count, which would leave a row stuck or reach an address past n-1. A polarity that toggled per row instead of per frame would also fail them. The bench also aims at the mode-specific level tables: a design that used V3 in mux 4 would break the zero-DC drive. The override combinations are covered as well: a design treating both overrides as blank would miss the resync. The bench also checks the external-frame realignment, where a wrong synchroniser depth would leave rows out of step with the master.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_VSS  = 3'd0;
  localparam lvl_t LVL_V3   = 3'd1;
  localparam lvl_t LVL_V2   = 3'd2;
  localparam lvl_t LVL_V1   = 3'd3;
  localparam lvl_t LVL_VLCD = 3'd4;

  function automatic logic [3:0] mux_rows(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [1:0] mux_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic lvl_t row_level(input logic four, input logic sel, input logic pol);
    if (!pol) return sel ? LVL_VSS : LVL_V1;
    else      return sel ? LVL_VLCD : (four ? LVL_V2 : LVL_V3);
  endfunction

  function automatic lvl_t col_level(input logic four, input logic on, input logic pol);
    if (!pol) return on ? LVL_VLCD : LVL_V2;
    else      return on ? LVL_VSS : (four ? LVL_V1 : LVL_V2);
  endfunction

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int FRAME_CLKS = 18176
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] shift,
  input  logic       restart,
  output logic       tick
);
  localparam int CW = $clog2(FRAME_CLKS) + 1;

  logic [CW-1:0] len_w;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign len_w = CW'(FRAME_CLKS) >> shift;
  assign tick  = !restart && (cnt_q >= len_w - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_w); // R2

endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rows,
  input  logic       col_only,
  input  logic       sync_req,
  input  logic       ext_fr,
  input  logic       tick,
  output logic [2:0] row_q,
  output logic       pol_q,
  output logic       load_q,
  output logic       restart
);
  logic       ext_s1_q, ext_s2_q, ext_prev_q;
  logic       ext_edge;
  logic       wrap_w;
  logic [2:0] row_d;
  logic       pol_d, load_d;

  assign ext_edge = col_only && (ext_s2_q != ext_prev_q);
  assign restart  = sync_req || ext_edge;
  assign wrap_w   = ({1'b0, row_q} >= rows - 4'd1);

  always_comb begin
    row_d  = row_q;
    pol_d  = pol_q;
    load_d = 1'b0;
    if (restart) begin
      row_d  = '0;
      load_d = 1'b1;
      pol_d  = col_only ? ext_s2_q : 1'b0;
    end else if (tick) begin
      load_d = 1'b1;
      if (wrap_w) begin
        row_d = '0;
        if (!col_only) pol_d = ~pol_q;
      end else begin
        row_d = row_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1_q   <= 1'b0;
      ext_s2_q   <= 1'b0;
      ext_prev_q <= 1'b0;
      row_q      <= '0;
      pol_q      <= 1'b0;
      load_q     <= 1'b1;
    end else begin
      ext_s1_q   <= ext_fr;
      ext_s2_q   <= ext_s1_q;
      ext_prev_q <= ext_s2_q;
      row_q      <= row_d;
      pol_q      <= pol_d;
      load_q     <= load_d;
    end
  end

  AST_RESTART_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (row_q == 3'd0) && load_q); // R10

  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_only && tick && wrap_w) |=> (pol_q != $past(pol_q))); // R3

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !(tick && wrap_w)) |=> $stable(pol_q)); // R3

endmodule

// File: rtl/lcd_drive_map.sv
module lcd_drive_map import lcd_scan_pkg::*; #(
  parameter int NUM_OUT = 60
) (
  input  logic [3:0]           rows,
  input  logic                 four_lvl,
  input  logic                 col_only,
  input  logic [2:0]           act_row,
  input  logic                 pol,
  input  logic [NUM_OUT-1:0]   pix,
  input  logic                 force_on,
  input  logic                 force_off,
  output logic [3*NUM_OUT-1:0] seg_lvl
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic is_row, is_sel, on;
    assign is_row = !col_only && ({28'd0, rows} > 32'(g));
    assign is_sel = ({29'd0, act_row} == 32'(g));
    assign on     = force_on | (~force_off & pix[g]);
    assign seg_lvl[3*g +: 3] = is_row ? row_level(four_lvl, is_sel, pol)
                                      : col_level(four_lvl, on, pol);
  end
endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner import lcd_scan_pkg::*; #(
  parameter int NUM_OUT    = 60,
  parameter int FRAME_CLKS = 18176
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mux_sel,
  input  logic                 col_only,
  input  logic                 blank,
  input  logic                 set_all,
  input  logic                 ext_fr,
  output logic [2:0]           ram_addr,
  input  logic [NUM_OUT-1:0]   ram_rdata,
  output logic                 fr_out,
  output logic [3*NUM_OUT-1:0] seg_lvl
);
  logic [3:0] rows_w;
  logic [1:0] shift_w;
  logic       four_lvl, sync_req, force_on, force_off;
  logic       tick, restart, load_q, pol_q;
  logic [2:0] row_q;

  logic [NUM_OUT-1:0] pix_q, pix_d;
  logic [2:0]         act_row_q, act_row_d;
  logic               act_pol_q, act_pol_d;

  assign rows_w    = mux_rows(mux_sel);
  assign shift_w   = mux_shift(mux_sel);
  assign four_lvl  = (mux_sel == 2'd1);
  assign sync_req  = blank & set_all;
  assign force_off = blank & ~set_all;
  assign force_on  = set_all & ~blank;

  lcd_timebase #(.FRAME_CLKS(FRAME_CLKS)) u_timebase (
    .clk(clk), .rst_n(rst_n), .shift(shift_w), .restart(restart), .tick(tick)
  );

  lcd_row_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rows(rows_w), .col_only(col_only),
    .sync_req(sync_req), .ext_fr(ext_fr), .tick(tick),
    .row_q(row_q), .pol_q(pol_q), .load_q(load_q), .restart(restart)
  );

  assign ram_addr = row_q;
  assign fr_out   = pol_q;

  always_comb begin
    pix_d     = pix_q;
    act_row_d = act_row_q;
    act_pol_d = act_pol_q;
    if (load_q) begin
      pix_d     = ram_rdata;
      act_row_d = row_q;
      act_pol_d = pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q     <= '0;
      act_row_q <= '0;
      act_pol_q <= 1'b0;
    end else begin
      pix_q     <= pix_d;
      act_row_q <= act_row_d;
      act_pol_q <= act_pol_d;
    end
  end

  lcd_drive_map #(.NUM_OUT(NUM_OUT)) u_map (
    .rows(rows_w), .four_lvl(four_lvl), .col_only(col_only),
    .act_row(act_row_q), .pol(act_pol_q), .pix(pix_q),
    .force_on(force_on), .force_off(force_off), .seg_lvl(seg_lvl)
  );

  // Checks on the emitted level codes
  logic codes_ok, no_v3, all_mid, all_ext;
  always_comb begin
    codes_ok = 1'b1;
    no_v3    = 1'b1;
    all_mid  = 1'b1;
    all_ext  = 1'b1;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (seg_lvl[3*i +: 3] > LVL_VLCD) codes_ok = 1'b0;
      if (seg_lvl[3*i +: 3] == LVL_V3)  no_v3    = 1'b0;
      if (seg_lvl[3*i +: 3] != LVL_V2)  all_mid  = 1'b0;
      if (seg_lvl[3*i +: 3] != LVL_VSS && seg_lvl[3*i +: 3] != LVL_VLCD) all_ext = 1'b0;
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> (pix_q == $past(ram_rdata)) && (act_row_q == $past(row_q))); // R4

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    codes_ok); // R6

  AST_MUX4_NO_V3: assert property (@(posedge clk) disable iff (!rst_n)
    four_lvl |-> no_v3); // R7

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (col_only && force_off && !four_lvl) |-> all_mid); // R8

  AST_SET_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (col_only && force_on) |-> all_ext); // R9

endmodule

// File: tb/lcd_row_scanner_tb.sv
module lcd_row_scanner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 12;
  localparam int FC = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            rst_n, col_only, blank, set_all, ext_fr;
  logic [1:0]      mux_sel;
  logic [2:0]      ram_addr;
  logic [NO-1:0]   ram_rdata;
  logic            fr_out;
  logic [3*NO-1:0] seg_lvl;
  logic [NO-1:0]   mem [8];

  assign ram_rdata = mem[ram_addr];

  int checks = 0;
  int errors = 0;

  lcd_row_scanner #(.NUM_OUT(NO), .FRAME_CLKS(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .col_only(col_only),
    .blank(blank), .set_all(set_all), .ext_fr(ext_fr), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .fr_out(fr_out), .seg_lvl(seg_lvl)
  );

  function automatic logic [3*NO-1:0] expv(int n, bit co, int row, int pol,
                                           logic [NO-1:0] bits, bit bl, bit st);
    logic [3*NO-1:0] v;
    v = '0;
    for (int i = 0; i < NO; i++) begin
      int c;
      if (!co && i < n) begin
        bit sel = (i == row);
        if (n == 4) c = pol ? (sel ? 4 : 2) : (sel ? 0 : 3);
        else        c = pol ? (sel ? 4 : 1) : (sel ? 0 : 3);
      end else begin
        bit on = (bl && !st) ? 1'b0 : (st && !bl) ? 1'b1 : bits[i];
        if (n == 4) c = pol ? (on ? 0 : 3) : (on ? 4 : 2);
        else        c = pol ? (on ? 0 : 2) : (on ? 4 : 2);
      end
      v[3*i +: 3] = c[2:0];
    end
    return v;
  endfunction

  task automatic chk(string tag, int n, bit co, int row, int pol, int addr,
                     int fr, bit bl, bit st, bit zero_latch);
    logic [NO-1:0]   bits;
    logic [3*NO-1:0] e;
    bits = zero_latch ? '0 : mem[row];
    e = expv(n, co, row, pol, bits, bl, st);
    checks++;
    if (seg_lvl !== e || ram_addr !== 3'(addr) || fr_out !== fr[0]) begin
      errors++;
      $display("FAIL %s: seg=%h addr=%0d fr=%0d expected seg=%h addr=%0d fr=%0d",
               tag, seg_lvl, ram_addr, fr_out, e, addr, fr);
    end
  endtask

  task automatic fill(int seed);
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < NO; i++)
        mem[r][i] = (((r*5 + i*3 + seed) % 7) < 3);
  endtask

  task automatic do_reset(logic [1:0] sel, bit co, int n);
    rst_n = 1'b0; mux_sel = sel; col_only = co;
    blank = 1'b0; set_all = 1'b0; ext_fr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", n, co, 0, 0, 0, 0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
  endtask

  // Sweep starting at the edge that follows a reset-like restart
  task automatic sweep(string tag, int n, bit co, int len, int pol0, bit slave, bit ovr);
    int l;
    l = FC / n;
    for (int m = 0; m < len; m++) begin
      bit bl, st;
      int pol, fr;
      bl = ovr && (m >= l && m < 2*l);
      st = ovr && (m >= 3*l && m < 4*l);
      @(posedge clk);
      @(negedge clk);
      blank = bl; set_all = st;
      #1;
      pol = slave ? pol0 : ((m / (n*l)) % 2);
      fr  = slave ? pol0 : (((m + 1) / (n*l)) % 2);
      chk(bl ? "R8" : st ? "R9" : tag, n, co, (m / l) % n, pol,
          ((m + 1) / l) % n, fr, bl, st, 1'b0);
    end
    blank = 1'b0; set_all = 1'b0;
  endtask

  task automatic run_master(logic [1:0] sel, int n, int seed, string tag);
    fill(seed);
    do_reset(sel, 1'b0, n);
    sweep(tag, n, 1'b0, 2*n*(FC/n) + FC/n, 0, 1'b0, 1'b1);
  endtask

  task automatic run_sync(int n);
    // mid-frame resynchronise with both overrides high (R10)
    repeat (3) @(posedge clk);
    @(negedge clk);
    blank = 1'b1; set_all = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R10", n, 1'b0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b0);
    blank = 1'b0; set_all = 1'b0;
    sweep("R10", n, 1'b0, FC + FC/n, 0, 1'b0, 1'b0);
  endtask

  task automatic run_slave(logic [1:0] sel, int n, int seed);
    fill(seed);
    do_reset(sel, 1'b1, n);
    sweep("R5", n, 1'b1, FC + FC/n, 0, 1'b1, 1'b1);
    @(negedge clk);
    ext_fr = 1'b1;
    repeat (3) @(posedge clk);
    sweep("R11", n, 1'b1, FC + FC/n, 1, 1'b1, 1'b0);
    @(negedge clk);
    ext_fr = 1'b0;
    repeat (3) @(posedge clk);
    sweep("R11", n, 1'b1, FC/2, 0, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mux_sel = 2'd0; col_only = 1'b0;
    blank = 1'b0; set_all = 1'b0; ext_fr = 1'b0;
    run_master(2'd0, 2, 1, "R2 R3 R4 R5 R6");
    run_master(2'd1, 4, 2, "R2 R3 R4 R5 R7");
    run_master(2'd2, 8, 3, "R2 R3 R4 R5 R6");
    run_sync(8);
    run_master(2'd3, 8, 4, "R12");
    run_sync(8);
    run_master(2'd1, 4, 7, "R7");
    run_sync(4);
    run_slave(2'd2, 8, 5);
    run_slave(2'd1, 4, 6);
    run_slave(2'd0, 2, 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule